// File: doc/BRIEF.md
# Fault-Injection Run Monitor

This block runs one fault-injection experiment and classifies its result. A processor core that receives injected faults runs next to an identical fault-free reference core. Both execute the same application and each keeps its results in its own 256-byte data memory. The monitor owns a second port on both memories. It also owns the reset of both cores and the window in which the fault generator may act.

A `start` pulse begins the sequence. The monitor clears its result flags, writes zero into every byte of both memories, and then releases both cores. While they run it times both cores' end-of-application signals. When both cores have finished, or when the timing rules give up on the faulted core, it puts the cores back into reset. It then reads both memories in step and compares them byte by byte. It ends with a one-cycle `done` pulse and keeps the flags, the first mismatching address and a 2-bit outcome code until the next `start`.

States: `S_IDLE` waits for `start`. `S_INIT` clears the flags (one cycle). `S_CLEAR` sweeps zero writes and leaves on the last address. `S_RUN` leaves when both ends are seen, on a lost-sequence timeout, or at the run cap. `S_SCAN` issues reads and leaves on the last address. `S_FLUSH` compares the final byte (one cycle). `S_DONE` returns to idle (one cycle).

Top module: `run_monitor`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: `core_rst`=1, `busy`=0, `mem_wr`=`mem_rd`=0, both flags are 0 and `status`=2'b00.
- R2: After `start` in idle, the block asserts `mem_wr` for exactly DEPTH consecutive cycles at addresses 0 up to DEPTH-1 in ascending order, with the cores held in reset.
- R3: `core_rst` falls only after the final clear write, and `inject_win` is high exactly while the cores are released. The run ends as soon as both end-of-application signals have been seen.
- R4: Let L be the run-cycle count at which the reference end was first seen. If the faulted core's end is still missing when the run counter reaches 2L, `lost_flag` is set and the run ends.
- R5: A run lasts at most MAX_RUN+1 cycles. If the faulted core has not ended by then, `lost_flag` is set; if it has ended, the run closes with no lost flag.
- R6: After the run, the block asserts `mem_rd` for exactly DEPTH consecutive cycles at ascending addresses with the cores in reset. Read data is expected one cycle after its address.
- R7: Any byte that differs between the two read-back memories sets the sticky `err_flag`. `first_err_addr` holds the lowest differing address, including addresses 0 and DEPTH-1.
- R8: `status` is 2'b00 for no effect, 2'b01 for a data error and 2'b10 for lost sequence. Lost sequence wins when both apply.
- R9: `done` is a single-cycle pulse after the last comparison. Flags, address and status stay unchanged while idle.
- R10: Memory contents left from reset or from an earlier run do not affect the outcome, because the clear sweep overwrites them.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one experiment (honoured only when idle) |
| app_end_dut | input | 1 | End-of-application signal of the faulted core |
| app_end_ref | input | 1 | End-of-application signal of the reference core |
| rd_data_dut | input | DATA_W | Read data from the faulted core's memory, one cycle after its address |
| rd_data_ref | input | DATA_W | Read data from the reference core's memory, one cycle after its address |
| mem_addr | output | ADDR_W | Address of the monitor's port on both memories |
| mem_wr | output | 1 | Write zero at `mem_addr` in both memories |
| mem_rd | output | 1 | Read `mem_addr` from both memories |
| core_rst | output | 1 | Reset held on both cores |
| inject_win | output | 1 | Window in which faults may be injected (cores running) |
| busy | output | 1 | Experiment in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| err_flag | output | 1 | Some byte differed |
| lost_flag | output | 1 | Faulted core lost its program sequence |
| status | output | 2 | Outcome code: 00 none, 01 data error, 10 lost |
| first_err_addr | output | ADDR_W | Lowest differing address |

## Verification
The assertions check the following on every cycle:
- both address sweeps advance by exactly one per cycle;
- the cores are released only right after the final clear write, and stay in reset during the scan;
- the lost and error flags, once set, hold (with the first error address kept) until the next experiment;
- `done` lasts a single cycle, and the outcome stays fixed while idle.

Only the bench scenarios can show the full outcome of a run. These cover:
- which outcome a run gets;
- the exact 2L and MAX_RUN limits;
- that stale memory contents are hidden by the clear;
- that a mid-run `start` is ignored.

// File: rtl/run_mon_pkg.sv
package run_mon_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_CLEAR,
        S_RUN,
        S_SCAN,
        S_FLUSH,
        S_DONE
    } mon_state_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'b00,
        RES_DATA = 2'b01,
        RES_LOST = 2'b10
    } run_result_e;

endpackage

// File: rtl/run_mon_fsm.sv
module run_mon_fsm
    import run_mon_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run_over,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              core_rst,
    output logic              inject_win,
    output logic              busy,
    output logic              done,
    output logic              init
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    mon_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              at_last;

    assign at_last = (addr_q == LAST_ADDR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_INIT;
            S_INIT:  state_d = S_CLEAR;
            S_CLEAR: if (at_last) state_d = S_RUN;
            S_RUN:   if (run_over) state_d = S_SCAN;
            S_SCAN:  if (at_last) state_d = S_FLUSH;
            S_FLUSH: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and sweep address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CLEAR || state_q == S_SCAN)
                addr_q <= at_last ? '0 : addr_q + 1'b1;
            else
                addr_q <= '0;
        end
    end

    // outputs
    always_comb begin
        mem_addr   = addr_q;
        mem_wr     = 1'b0;
        mem_rd     = 1'b0;
        core_rst   = 1'b1;
        inject_win = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        init       = 1'b0;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_INIT:  init = 1'b1;
            S_CLEAR: mem_wr = 1'b1;
            S_RUN: begin
                core_rst   = 1'b0;
                inject_win = 1'b1;
            end
            S_SCAN:  mem_rd = 1'b1;
            S_FLUSH: ;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    a_r2_clear_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && $past(mem_wr) |-> mem_addr == $past(mem_addr) + 1'b1);

    a_r6_scan_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + 1'b1);

    a_r3_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> $past(mem_wr) && $past(mem_addr) == LAST_ADDR);

    a_r6_cores_held_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> core_rst && !inject_win);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/run_mon_timer.sv
module run_mon_timer #(
    parameter int CNT_W   = 16,
    parameter int MAX_RUN = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic app_end_dut,
    input  logic app_end_ref,
    output logic run_over,
    output logic lost
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_RUN);

    logic [CNT_W-1:0] cnt_q, ref_len_q;
    logic             ref_seen_q, dut_seen_q, lost_q;
    logic             dut_fin, ref_fin, at_cap, overdue, late;

    assign dut_fin  = dut_seen_q | app_end_dut;
    assign ref_fin  = ref_seen_q | app_end_ref;
    assign at_cap   = (cnt_q == CAP);
    assign overdue  = ref_seen_q && ({1'b0, cnt_q} >= {ref_len_q, 1'b0});
    assign late     = run && !dut_fin && (overdue || at_cap);
    assign run_over = run && ((dut_fin && ref_fin) || late || at_cap);
    assign lost     = lost_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q      <= '0;
            ref_len_q  <= '0;
            ref_seen_q <= 1'b0;
            dut_seen_q <= 1'b0;
        end else begin
            if (!at_cap) cnt_q <= cnt_q + 1'b1;
            if (app_end_ref && !ref_seen_q) begin
                ref_seen_q <= 1'b1;
                ref_len_q  <= cnt_q;
            end
            if (app_end_dut) dut_seen_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) lost_q <= 1'b0;
        else if (late)     lost_q <= 1'b1;
    end

    a_r4_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lost && !clr |=> lost);

    a_r4_lost_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(run));

endmodule

// File: rtl/run_mon_cmp.sv
module run_mon_cmp #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] rd_dut,
    input  logic [DATA_W-1:0] rd_ref,
    output logic              err,
    output logic [ADDR_W-1:0] first_addr
);

    logic              valid_q, err_q;
    logic [ADDR_W-1:0] addr_q, first_q;
    logic              mismatch;

    assign mismatch   = valid_q && (rd_dut != rd_ref);
    assign err        = err_q;
    assign first_addr = first_q;

    // one-cycle read latency: the address travels with the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= issue;
            addr_q  <= issue_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_q   <= 1'b0;
            first_q <= '0;
        end else if (mismatch && !err_q) begin
            err_q   <= 1'b1;
            first_q <= addr_q;
        end
    end

    a_r7_first_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        err && !clr |=> err && $stable(first_addr));

endmodule

// File: rtl/run_monitor.sv
module run_monitor
    import run_mon_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 16,
    parameter int MAX_RUN = 50000,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              app_end_dut,
    input  logic              app_end_ref,
    input  logic [DATA_W-1:0] rd_data_dut,
    input  logic [DATA_W-1:0] rd_data_ref,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              core_rst,
    output logic              inject_win,
    output logic              busy,
    output logic              done,
    output logic              err_flag,
    output logic              lost_flag,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] first_err_addr
);

    logic init, run_over;

    run_mon_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run_over   (run_over),
        .mem_addr   (mem_addr),
        .mem_wr     (mem_wr),
        .mem_rd     (mem_rd),
        .core_rst   (core_rst),
        .inject_win (inject_win),
        .busy       (busy),
        .done       (done),
        .init       (init)
    );

    run_mon_timer #(.CNT_W(CNT_W), .MAX_RUN(MAX_RUN)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (inject_win),
        .clr         (init),
        .app_end_dut (app_end_dut),
        .app_end_ref (app_end_ref),
        .run_over    (run_over),
        .lost        (lost_flag)
    );

    run_mon_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (init),
        .issue      (mem_rd),
        .issue_addr (mem_addr),
        .rd_dut     (rd_data_dut),
        .rd_ref     (rd_data_ref),
        .err        (err_flag),
        .first_addr (first_err_addr)
    );

    always_comb begin
        if (lost_flag)     status = RES_LOST;
        else if (err_flag) status = RES_DATA;
        else               status = RES_NONE;
    end

    a_r9_result_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && $past(!busy) |-> $stable(status) && $stable(first_err_addr));

    a_r11_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

endmodule

// File: tb/run_monitor_test.sv
`timescale 1ns/1ps
module run_monitor_test;

    localparam int DEPTH = 256;
    localparam int MAXR  = 300;
    localparam int FILL  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       app_end_dut = 1'b0;
    logic       app_end_ref = 1'b0;
    logic [7:0] rd_d = 8'h00;
    logic [7:0] rd_r = 8'h00;
    logic [7:0] mem_addr;
    logic       mem_wr, mem_rd, core_rst, inject_win, busy, done, err_flag, lost_flag;
    logic [1:0] status;
    logic [7:0] first_err_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    run_monitor #(.DEPTH(DEPTH), .DATA_W(8), .CNT_W(16), .MAX_RUN(MAXR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .app_end_dut(app_end_dut), .app_end_ref(app_end_ref),
        .rd_data_dut(rd_d), .rd_data_ref(rd_r),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .core_rst(core_rst), .inject_win(inject_win), .busy(busy), .done(done),
        .err_flag(err_flag), .lost_flag(lost_flag), .status(status),
        .first_err_addr(first_err_addr)
    );

    // scenario configuration, written only by the main sequence
    logic [7:0] flip [DEPTH];
    int ref_at = 0;
    int dut_at = 0;

    // memory models, core result writes and sweep observers
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_r [DEPTH];
    logic filled;
    int wr_n, rd_n, inj_n;
    bit ord_bad, run_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] <= 8'(i);
                mem_r[i] <= ~8'(i);
            end
            filled <= 1'b0;
            wr_n <= 0; rd_n <= 0; inj_n <= 0; ord_bad <= 1'b0; run_bad <= 1'b0;
        end else begin
            if (mem_wr) begin
                mem_d[mem_addr] <= 8'h00;
                mem_r[mem_addr] <= 8'h00;
            end
            if (mem_rd) begin
                rd_d <= mem_d[mem_addr];
                rd_r <= mem_r[mem_addr];
            end
            if (core_rst) filled <= 1'b0;
            else if (!filled) begin
                filled <= 1'b1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (i < FILL) begin
                        mem_r[i] <= 8'(i * 7 + 3);
                        mem_d[i] <= 8'(i * 7 + 3) ^ flip[i];
                    end else if (flip[i] != 8'h00) begin
                        mem_d[i] <= flip[i];
                    end
                end
            end
            if (start && !busy) begin
                wr_n <= 0; rd_n <= 0; inj_n <= 0; ord_bad <= 1'b0; run_bad <= 1'b0;
            end else begin
                if (mem_wr) begin
                    wr_n <= wr_n + 1;
                    if (int'(mem_addr) != wr_n) ord_bad <= 1'b1;
                end
                if (mem_rd) begin
                    rd_n <= rd_n + 1;
                    if (int'(mem_addr) != rd_n) ord_bad <= 1'b1;
                end
                if (inject_win) inj_n <= inj_n + 1;
                if (!core_rst && (mem_wr || mem_rd)) run_bad <= 1'b1;
                if (inject_win == core_rst) run_bad <= 1'b1;
            end
        end
    end

    // core end-of-application models, driven away from the active edge
    always @(negedge clk) begin
        static int k = 0;
        if (core_rst) begin
            k = 0;
            app_end_ref = 1'b0;
            app_end_dut = 1'b0;
        end else begin
            k++;
            app_end_ref = (ref_at > 0) && (k >= ref_at);
            app_end_dut = (dut_at > 0) && (k >= dut_at);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flips();
        for (int i = 0; i < DEPTH; i++) flip[i] = 8'h00;
    endtask

    // one full experiment, then checks of sweeps and outcome
    task automatic run_case(input int r_at, input int d_at, input int exp_st,
                            input int exp_addr, input bit poke_start, input int exp_inj);
        int cyc = 0;
        bit seen = 1'b0;
        ref_at = r_at;
        dut_at = d_at;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!seen && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (poke_start && cyc == 300) start = 1'b1;  // R11: mid-run start
            if (poke_start && cyc == 301) start = 1'b0;
            if (done) seen = 1'b1;
        end
        check(seen, "R9 done pulse", int'(seen), 1);
        check(wr_n == DEPTH, "R2 clear writes", wr_n, DEPTH);
        check(rd_n == DEPTH, "R6 scan reads", rd_n, DEPTH);
        check(!ord_bad, "R2/R6 ascending order", int'(ord_bad), 0);
        check(!run_bad, "R3 release window", int'(run_bad), 0);
        if (exp_inj > 0) check(inj_n == exp_inj, "R5 run cap length", inj_n, exp_inj);
        else             check(inj_n > 0 && inj_n < 60, "R3 early run end", inj_n, 20);
        check(int'(status) == exp_st, "R8 status code", int'(status), exp_st);
        check(lost_flag == (exp_st == 2), "R4 lost flag", int'(lost_flag), int'(exp_st == 2));
        check(err_flag == (exp_addr >= 0), "R7 error flag", int'(err_flag), int'(exp_addr >= 0));
        if (exp_addr >= 0)
            check(int'(first_err_addr) == exp_addr, "R7 first address", int'(first_err_addr), exp_addr);
        @(negedge clk);
        check(!done, "R9 done single cycle", int'(done), 0);
        repeat (5) @(negedge clk);
        check(!busy, "R11 no restart", int'(busy), 0);
        check(int'(status) == exp_st, "R9 status held", int'(status), exp_st);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check(core_rst && !busy && !mem_wr && !mem_rd, "R1 idle outputs",
              int'({core_rst, busy, mem_wr, mem_rd}), 8);
        check(!err_flag && !lost_flag && status == 2'b00, "R1 flags clear",
              int'({err_flag, lost_flag, status}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(core_rst && !busy && status == 2'b00, "R1 after release",
              int'({core_rst, busy, status}), 8);
    endtask

    task automatic t_clean();   // R10: reset-time junk differs above FILL
        clear_flips();
        run_case(10, 12, 0, -1, 1'b0, 0);
    endtask

    task automatic t_data_error();   // R7 and R11
        clear_flips();
        flip[8'h37] = 8'h01;
        flip[8'h90] = 8'h80;
        run_case(10, 12, 1, 8'h37, 1'b1, 0);
    endtask

    task automatic t_stale_after_error();   // R10: stale byte at 0x90 hidden
        clear_flips();
        run_case(10, 12, 0, -1, 1'b0, 0);
    endtask

    task automatic t_edges();   // R7 boundaries
        clear_flips();
        flip[DEPTH-1] = 8'h44;
        run_case(10, 12, 1, DEPTH - 1, 1'b0, 0);
        clear_flips();
        flip[0] = 8'hFF;
        flip[200] = 8'h01;
        run_case(10, 12, 1, 0, 1'b0, 0);
    endtask

    task automatic t_lost_priority();   // R4 and R8
        clear_flips();
        flip[5] = 8'h10;
        run_case(10, 0, 2, 5, 1'b0, -1);
    endtask

    task automatic t_late_end();   // R4: ends well after 2L
        clear_flips();
        run_case(10, 40, 2, -1, 1'b0, -1);
    endtask

    task automatic t_cap();   // R5
        clear_flips();
        run_case(0, 0, 2, -1, 1'b0, MAXR + 1);
        run_case(0, 15, 0, -1, 1'b0, MAXR + 1);
    endtask

    // the lost runs take 2L cycles; accept any short length there
    initial begin
        t_reset();
        t_clean();
        t_data_error();
        t_stale_after_error();
        t_edges();
        t_lost_priority();
        t_late_end();
        t_cap();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule